// File: doc/BRIEF.md
# Dimming Burst Clock Selector

This block produces the burst-rate timing for the digital dimming of a backlight inverter. Two three-level selection codes, already resolved from their pins into low, open or high, control it. The mode code picks one of three behaviours. Analog dimming produces no burst timing and holds the burst enable on. Digital dimming takes its timing either from an external dimming clock or from an internal source at half the reference oscillator rate. The ratio code then divides the chosen source by 2, 4 or 8.

The external clock is asynchronous to the system clock and may run at any rate up to 200 kHz. It is synchronised and edge-detected before it is counted. In analog mode the same input selects the dimming polarity, and the block keeps it in a registered flag. Whenever either code changes, the divider and the internal halving phase restart, so no shortened burst period follows a reconfiguration. The burst output is a single system-clock pulse for each divided source edge.

Top module: `burst_clk_sel`

## Requirements
- R1: While reset is held, burst_tick and burst_en read 0, analog_mode reads 1 and polarity_up reads 1.
- R2: The code values are 2'b00 low, 2'b01 open, 2'b10 high, and 2'b11 counts as open (mid-level). A mode code of open (2'b01 or 2'b11) selects analog dimming. In that mode analog_mode is 1 and burst_tick stays 0. From the second clock after entering that mode, burst_en stays 1.
- R3: A mode code of high (2'b10) selects the external clock. One burst_tick is produced for every N synchronised rising edges of ext_dim_clk, and ref_tick has no effect.
- R4: A mode code of low (2'b00) selects the internal source, which is one edge for every two ref_tick pulses. One burst_tick is produced for every N such edges, and ext_dim_clk has no effect on the tick count.
- R5: The ratio N comes from div_lvl: high (2'b10) gives 2, open (2'b01 or 2'b11) gives 4, low (2'b00) gives 8.
- R6: ext_dim_clk passes through a two-flop synchroniser and a rising-edge detector. A rising edge that completes the ratio is first sampled high at some clock edge, and burst_tick is high after the third clock edge counted from that one.
- R7: burst_tick is never high for two cycles in a row. In digital mode, burst_en is equal to burst_tick.
- R8: Any change of mode_lvl or div_lvl clears the ratio counter and the internal halving phase, and no tick is produced in the cycle after the change. Counting restarts from zero.
- R9: In analog mode, polarity_up follows the synchronised ext_dim_clk level three clock edges later (1 = brightness rises with control voltage, 0 = it falls). In digital mode it holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_lvl | input | 2 | Resolved three-level dimming mode code |
| div_lvl | input | 2 | Resolved three-level ratio code |
| ext_dim_clk | input | 1 | Asynchronous external dimming clock, or polarity level in analog mode |
| ref_tick | input | 1 | One-cycle pulse per reference oscillator period |
| burst_tick | output | 1 | One-cycle pulse per divided source edge |
| burst_en | output | 1 | Burst enable: held high in analog mode, equal to burst_tick otherwise |
| analog_mode | output | 1 | High while the registered mode is analog |
| polarity_up | output | 1 | Registered dimming polarity |

## Verification
The hardest case to reach is a code change in the middle of a count. A counter left over from the earlier ratio would turn the next period into a runt or stretch it, and the tick count alone rarely shows this. Directed sequences therefore stop a run partway through a ratio of 8 and switch to a ratio of 2, or switch from the external source to the internal one after an odd number of edges. The expected tick count after the switch is exact only if the counter and the halving phase were both cleared. Random runs go through a different code on the way to each target setting, so every run starts from a known phase and can be checked against a simple quotient.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_OPEN = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_MID  = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    SRC_ANALOG = 2'b00,
    SRC_EXT    = 2'b01,
    SRC_INT    = 2'b10
  } src_e;

  function automatic src_e decode_mode(input logic [1:0] code);
    case (code)
      LVL_HIGH: decode_mode = SRC_EXT;
      LVL_LOW:  decode_mode = SRC_INT;
      default:  decode_mode = SRC_ANALOG;
    endcase
  endfunction

endpackage

// File: rtl/bcs_sync_edge.sv
module bcs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] shreg;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      prev_q <= 1'b0;
    end else begin
      shreg  <= {shreg[STAGES-2:0], async_in};
      prev_q <= shreg[STAGES-1];
    end
  end

  assign level_o = shreg[STAGES-1];
  assign rise_o  = shreg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/bcs_src_select.sv
module bcs_src_select
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_lvl,
  input  logic [1:0] div_lvl,
  input  logic       ext_rise,
  input  logic       ref_tick,
  output logic       src_ev,
  output logic       restart,
  output src_e       src_sel,
  output logic [1:0] div_q
);
  logic [1:0] mode_q;
  logic       half_ph;

  assign restart = (mode_lvl != mode_q) || (div_lvl != div_q);
  assign src_sel = decode_mode(mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= LVL_OPEN;
      div_q   <= LVL_OPEN;
      half_ph <= 1'b0;
    end else begin
      mode_q <= mode_lvl;
      div_q  <= div_lvl;
      if (restart)
        half_ph <= 1'b0;
      else if (src_sel == SRC_INT && ref_tick)
        half_ph <= ~half_ph;
    end
  end

  always_comb begin
    src_ev = 1'b0;
    if (!restart) begin
      case (src_sel)
        SRC_EXT: src_ev = ext_rise;
        SRC_INT: src_ev = ref_tick & half_ph;
        default: src_ev = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bcs_ratio_div.sv
module bcs_ratio_div
  import bcs_pkg::*;
#(
  parameter int RATIO_HI  = 2,
  parameter int RATIO_MID = 4,
  parameter int RATIO_LO  = 8,
  parameter int CNT_W     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] div_code,
  input  logic       restart,
  input  logic       src_ev,
  input  logic       analog,
  output logic       tick_o,
  output logic       en_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n, last_cnt;
  logic             tick_n;

  always_comb begin
    case (div_code)
      LVL_HIGH: last_cnt = CNT_W'(RATIO_HI - 1);
      LVL_LOW:  last_cnt = CNT_W'(RATIO_LO - 1);
      default:  last_cnt = CNT_W'(RATIO_MID - 1);
    endcase
  end

  always_comb begin
    cnt_n  = cnt_q;
    tick_n = 1'b0;
    if (restart) begin
      cnt_n = '0;
    end else if (src_ev) begin
      if (cnt_q >= last_cnt) begin
        cnt_n  = '0;
        tick_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
      en_o   <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      tick_o <= tick_n;
      en_o   <= analog | tick_n;
    end
  end
endmodule

// File: rtl/burst_clk_sel.sv
module burst_clk_sel
  import bcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RATIO_HI    = 2,
  parameter int RATIO_MID   = 4,
  parameter int RATIO_LO    = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_lvl,
  input  logic [1:0] div_lvl,
  input  logic       ext_dim_clk,
  input  logic       ref_tick,
  output logic       burst_tick,
  output logic       burst_en,
  output logic       analog_mode,
  output logic       polarity_up
);
  localparam int CNT_W = $clog2(RATIO_LO + 1);

  logic       ext_level, ext_rise, src_ev, restart;
  src_e       src_sel;
  logic [1:0] div_q;
  logic       pol_q;

  bcs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_dim_clk),
    .level_o(ext_level), .rise_o(ext_rise)
  );

  bcs_src_select u_sel (
    .clk(clk), .rst(rst), .mode_lvl(mode_lvl), .div_lvl(div_lvl),
    .ext_rise(ext_rise), .ref_tick(ref_tick), .src_ev(src_ev),
    .restart(restart), .src_sel(src_sel), .div_q(div_q)
  );

  bcs_ratio_div #(
    .RATIO_HI(RATIO_HI), .RATIO_MID(RATIO_MID),
    .RATIO_LO(RATIO_LO), .CNT_W(CNT_W)
  ) u_div (
    .clk(clk), .rst(rst), .div_code(div_q), .restart(restart),
    .src_ev(src_ev), .analog(src_sel == SRC_ANALOG),
    .tick_o(burst_tick), .en_o(burst_en)
  );

  always_ff @(posedge clk) begin
    if (rst)
      pol_q <= 1'b1;
    else if (src_sel == SRC_ANALOG)
      pol_q <= ext_level;
  end

  assign polarity_up = pol_q;
  assign analog_mode = (src_sel == SRC_ANALOG);
endmodule

// File: rtl/burst_clk_sel_chk.sv
module burst_clk_sel_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_lvl,
  input logic [1:0] div_lvl,
  input logic       burst_tick,
  input logic       burst_en,
  input logic       analog_mode,
  input logic       polarity_up
);
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    burst_tick |=> !burst_tick); // R7
  AST_DIG_EN_MATCH: assert property (@(posedge clk) disable iff (rst)
    !$past(analog_mode) |-> (burst_en == burst_tick)); // R7
  AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (rst)
    analog_mode |-> !burst_tick); // R2
  AST_ANALOG_EN: assert property (@(posedge clk) disable iff (rst)
    ($past(analog_mode) && !$past(rst)) |-> burst_en); // R2
  AST_POL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !analog_mode |=> $stable(polarity_up)); // R9
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (mode_lvl != $past(mode_lvl) || div_lvl != $past(div_lvl)))
    |=> !burst_tick); // R8
endmodule

bind burst_clk_sel burst_clk_sel_chk u_chk (.*);

// File: tb/tb_burst_clk_sel.sv
module tb_burst_clk_sel;
  logic       clk = 1'b0, rst = 1'b1;
  logic [1:0] mode_lvl = 2'b01, div_lvl = 2'b01;
  logic       ext_dim_clk = 1'b0, ref_tick = 1'b0;
  logic       burst_tick, burst_en, analog_mode, polarity_up;
  int         n_cmp = 0, n_bad = 0, tick_cnt = 0;
  logic       done = 1'b0;

  burst_clk_sel dut (.*);

  always #5 clk = ~clk;

  always @(negedge clk) if (!rst && burst_tick) tick_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [1:0] d);
    if (d == 2'b10) return 2;
    if (d == 2'b00) return 8;
    return 4;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // go through an analog code first so the divider always restarts (R8)
  task automatic set_codes(input logic [1:0] m, input logic [1:0] d);
    ext_dim_clk = 1'b0; ref_tick = 1'b0;
    mode_lvl = (m == 2'b11) ? 2'b01 : 2'b11;
    idle(3);
    mode_lvl = m; div_lvl = d;
    idle(6);
    tick_cnt = 0;
  endtask

  task automatic pulse_ext(input int k, input bit ref_noise);
    for (int i = 0; i < k; i++) begin
      int hi, lo;
      hi = $urandom_range(1, 5); lo = $urandom_range(1, 5);
      ext_dim_clk = 1'b1;
      repeat (hi) begin ref_tick = ref_noise & $urandom_range(0, 1); @(negedge clk); end
      ext_dim_clk = 1'b0;
      repeat (lo) begin ref_tick = ref_noise & $urandom_range(0, 1); @(negedge clk); end
    end
    ref_tick = 1'b0;
  endtask

  task automatic pulse_ref(input int k, input bit ext_noise);
    for (int i = 0; i < k; i++) begin
      int gap;
      gap = $urandom_range(0, 3);
      ref_tick = 1'b1; ext_dim_clk = ext_noise & $urandom_range(0, 1);
      @(negedge clk);
      ref_tick = 1'b0;
      repeat (gap) begin ext_dim_clk = ext_noise & $urandom_range(0, 1); @(negedge clk); end
    end
    ext_dim_clk = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    idle(5);
    chk("R1 tick", burst_tick, 0);
    chk("R1 en", burst_en, 0);
    chk("R1 analog", analog_mode, 1);
    chk("R1 polarity", polarity_up, 1);
    rst = 1'b0;

    // R6 latency at ratio 2
    set_codes(2'b10, 2'b10);
    pulse_ext(1, 0);
    idle(6);
    chk("R6 no tick after first edge", tick_cnt, 0);
    ext_dim_clk = 1'b1;
    @(negedge clk); chk("R6 edge1", burst_tick, 0);
    @(negedge clk); chk("R6 edge2", burst_tick, 0);
    @(negedge clk); chk("R6 edge3 tick", burst_tick, 1);
    chk("R7 en follows tick", burst_en, 1);
    @(negedge clk); chk("R7 single cycle", burst_tick, 0);
    ext_dim_clk = 1'b0; idle(6);

    // R3/R5 exact boundaries per ratio, ext source, ref noise ignored
    for (int d = 0; d < 3; d++) begin
      logic [1:0] dc;
      int n;
      dc = (d == 0) ? 2'b10 : (d == 1) ? 2'b01 : 2'b00;
      n = ratio_of(dc);
      set_codes(2'b10, dc);
      pulse_ext(n - 1, 1); idle(8);
      chk("R5 ext one short of ratio", tick_cnt, 0);
      pulse_ext(1, 1); idle(8);
      chk("R3 ext full ratio", tick_cnt, 1);
    end

    // R4 internal halving, ext ignored
    set_codes(2'b00, 2'b10);
    pulse_ref(3, 1); idle(8);
    chk("R4 three ref pulses", tick_cnt, 0);
    pulse_ref(1, 1); idle(8);
    chk("R4 four ref pulses", tick_cnt, 1);
    set_codes(2'b00, 2'b11);
    pulse_ref(8, 1); idle(8);
    chk("R5 mid code 11 ratio 4", tick_cnt, 1);

    // R8 ratio change mid-count
    set_codes(2'b10, 2'b00);
    pulse_ext(5, 0); idle(6);
    div_lvl = 2'b10; idle(6);
    pulse_ext(3, 0); idle(8);
    chk("R8 ratio change restarts", tick_cnt, 1);
    // R8 mode change mid-count resets halving phase
    set_codes(2'b00, 2'b10);
    pulse_ref(3, 0); idle(6);
    mode_lvl = 2'b10; idle(4);
    mode_lvl = 2'b00; idle(4);
    pulse_ref(3, 0); idle(8);
    chk("R8 halving phase cleared", tick_cnt, 0);

    // R2/R9 analog mode
    set_codes(2'b11, 2'b10);
    ext_dim_clk = 1'b1; idle(5);
    chk("R9 polarity high", polarity_up, 1);
    chk("R2 analog flag", analog_mode, 1);
    ext_dim_clk = 1'b0; idle(5);
    chk("R9 polarity low", polarity_up, 0);
    begin
      int en_low;
      en_low = 0;
      for (int i = 0; i < 40; i++) begin
        ext_dim_clk = $urandom_range(0, 1); ref_tick = $urandom_range(0, 1);
        @(negedge clk);
        if (!burst_en) en_low++;
      end
      chk("R2 en held in analog", en_low, 0);
      chk("R2 no ticks in analog", tick_cnt, 0);
    end
    ext_dim_clk = 1'b0; ref_tick = 1'b0; idle(5);
    mode_lvl = 2'b10; idle(3);
    pulse_ext(6, 0); idle(4);
    chk("R9 polarity holds in digital", polarity_up, 0);

    // random runs
    for (int it = 0; it < 40; it++) begin
      logic [1:0] m, d;
      int k, exp;
      m = 2'($urandom_range(0, 3)); d = 2'($urandom_range(0, 3));
      k = $urandom_range(1, 20);
      set_codes(m, d);
      if (m == 2'b10) begin
        pulse_ext(k, 1); exp = k / ratio_of(d);
      end else if (m == 2'b00) begin
        pulse_ref(k, 1); exp = k / (2 * ratio_of(d));
      end else begin
        pulse_ext(k, 1); exp = 0;
      end
      idle(8);
      chk("R3 R4 R2 random tick count", tick_cnt, exp);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule